// File: doc/BRIEF.md
# Two-Port RAM with Address-Clash Arbitration

This block is a synchronous word-wide memory with two fully independent access ports, called left and right. Each port has its own active-low select, read/not-write strobe, active-low output enable, byte-lane enables, address and data lines. Either port can read or write any word in any cycle. When both ports select the same word, an arbiter picks one owner and raises a busy flag toward the other port.

A mode input chooses how the block handles a clash. In arbitrating mode the block decides on its own. It drives a busy output to the losing port and suppresses that port's writes for as long as the clash lasts. In follower mode the busy outputs stay low and a per-port busy input takes their place. A port's write is held off while its busy input is high. This lets a group of blocks share one arbitrating instance to form a wider word.

The arbiter is a three-state machine. ARB_IDLE means no clash. ARB_LEFT means the left port owns the clashing word. ARB_RIGHT means the right port owns it. The transitions are as follows. From ARB_IDLE, a new clash moves the machine to ARB_RIGHT if the right port was already at that word in the previous cycle and the left port is new to it; otherwise it moves to ARB_LEFT. ARB_LEFT and ARB_RIGHT stay put while the clash lasts and fall back to ARB_IDLE once it ends. A port counts as new to a word when it was not selected in the previous cycle or when its address has changed since then.

Top module: `dpr_top`

## Requirements
- R1: After reset, both read data buses are zero, both drive flags are 0 and both busy outputs are 0.
- R2: A port is in write mode when select is 0 and read/not-write is 0, and in read mode when select is 0, read/not-write is 1 and output enable is 0. A read returns the word on the data bus one cycle later, with the drive flag at 1. If select is 1 or output enable is 1, the next cycle shows a drive flag of 0 and a data bus of zero.
- R3: Byte-enable bit i (1 = write) controls data bits 8i+7..8i of a write; lanes whose enable is 0 keep their contents.
- R4: When the two selected addresses differ, neither busy output rises and both ports read and write in the same cycle without affecting each other.
- R5: In arbitrating mode, a clash (both ports selected at equal addresses) raises exactly one busy output in the same cycle. The two busy outputs are never high together.
- R6: The port that reached the clashing word in an earlier cycle owns it. Busy goes to the other port and stays there for as long as the clash lasts.
- R7: When both ports reach the clashing word in the same cycle, the left port wins and the right busy output rises.
- R8: In arbitrating mode, a write from the port that receives busy leaves the memory unchanged.
- R9: Busy drops in the same cycle that the addresses stop matching or that either port is deselected.
- R10: In follower mode (mode input 0), both busy outputs stay 0. A port's write is blocked while its busy input is 1 and goes through normally once that input is 0.
- R11: A read is issued in the same cycle as a write by the other port to the same word. The read returns the newly written bytes one cycle later.
- R12: When both ports write the same word in the same cycle without being blocked, the left port's enabled bytes prevail and the right port's other enabled bytes are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_i | input | 1 | 1 = arbitrating mode, 0 = follower mode |
| lf_cs_n | input | 1 | Left select, active low |
| lf_rnw | input | 1 | Left read (1) / write (0) |
| lf_oe_n | input | 1 | Left output enable, active low |
| lf_be | input | DATA_W/8 | Left byte-lane write enables |
| lf_addr | input | ADDR_W | Left word address |
| lf_wdata | input | DATA_W | Left write data |
| lf_rdata | output | DATA_W | Left read data, zero when not driven |
| lf_drive | output | 1 | Left read data valid / bus driven |
| lf_busy_o | output | 1 | Busy toward left port (arbitrating mode) |
| lf_busy_i | input | 1 | External busy for left port (follower mode) |
| rt_cs_n | input | 1 | Right select, active low |
| rt_rnw | input | 1 | Right read (1) / write (0) |
| rt_oe_n | input | 1 | Right output enable, active low |
| rt_be | input | DATA_W/8 | Right byte-lane write enables |
| rt_addr | input | ADDR_W | Right word address |
| rt_wdata | input | DATA_W | Right write data |
| rt_rdata | output | DATA_W | Right read data, zero when not driven |
| rt_drive | output | 1 | Right read data valid / bus driven |
| rt_busy_o | output | 1 | Busy toward right port (arbitrating mode) |
| rt_busy_i | input | 1 | External busy for right port (follower mode) |

## Verification
The busy outputs are combinational on the current port inputs. The bench therefore drives each stimulus just after a falling edge and samples busy one nanosecond later, within the same cycle. Read data and drive flags appear after the first rising edge that follows the read request, and the bench samples them at the next falling edge. A suppressed or blocked write is checked by a read one cycle after the conflict has cleared, which shows that the word kept its old value. The pass-through case (R11) samples the reader's bus one edge after the shared write and read cycle.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

    typedef enum logic [1:0] {
        ARB_IDLE  = 2'd0,
        ARB_LEFT  = 2'd1,
        ARB_RIGHT = 2'd2
    } arb_state_t;

    localparam int LANE_W = 8;

endpackage

// File: rtl/dpr_arbiter.sv
module dpr_arbiter
    import dpr_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          master,
    input  logic          lf_sel,
    input  logic          rt_sel,
    input  logic [AW-1:0] lf_addr,
    input  logic [AW-1:0] rt_addr,
    output logic          lf_busy,
    output logic          rt_busy
);

    arb_state_t    state_q, state_d, owner;
    logic          lf_sel_q, rt_sel_q;
    logic [AW-1:0] lf_addr_q, rt_addr_q;
    logic          clash, lf_new, rt_new;

    always_comb begin
        clash  = lf_sel && rt_sel && (lf_addr == rt_addr);
        lf_new = !lf_sel_q || (lf_addr_q != lf_addr);
        rt_new = !rt_sel_q || (rt_addr_q != rt_addr);
    end

    // next-state logic
    always_comb begin
        state_d = ARB_IDLE;
        unique case (state_q)
            ARB_IDLE: begin
                if (clash)
                    state_d = (lf_new && !rt_new) ? ARB_RIGHT : ARB_LEFT;
            end
            ARB_LEFT, ARB_RIGHT: begin
                state_d = clash ? state_q : ARB_IDLE;
            end
            default: state_d = ARB_IDLE;
        endcase
    end

    // state register and arrival history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ARB_IDLE;
            lf_sel_q  <= 1'b0;
            rt_sel_q  <= 1'b0;
            lf_addr_q <= '0;
            rt_addr_q <= '0;
        end else begin
            state_q   <= state_d;
            lf_sel_q  <= lf_sel;
            rt_sel_q  <= rt_sel;
            lf_addr_q <= lf_addr;
            rt_addr_q <= rt_addr;
        end
    end

    // outputs: the loser of a live clash is flagged in the same cycle
    always_comb begin
        owner   = (state_q == ARB_IDLE) ? state_d : state_q;
        lf_busy = master && clash && (owner == ARB_RIGHT);
        rt_busy = master && clash && (owner == ARB_LEFT);
    end

endmodule

// File: rtl/dpr_store.sv
module dpr_store
    import dpr_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 32
) (
    input  logic             clk,
    input  logic             lf_we,
    input  logic [DW/8-1:0]  lf_be,
    input  logic [AW-1:0]    lf_addr,
    input  logic [DW-1:0]    lf_wdata,
    input  logic             rt_we,
    input  logic [DW/8-1:0]  rt_be,
    input  logic [AW-1:0]    rt_addr,
    input  logic [DW-1:0]    rt_wdata,
    output logic [DW-1:0]    lf_rword,
    output logic [DW-1:0]    rt_rword
);

    localparam int NB    = DW / LANE_W;
    localparam int DEPTH = 1 << AW;

    logic same_word;
    assign same_word = (lf_addr == rt_addr);

    for (genvar b = 0; b < NB; b++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];
        logic              lf_hit, rt_hit;

        assign lf_hit = lf_we && lf_be[b];
        assign rt_hit = rt_we && rt_be[b];

        // right lane first, left last: left prevails on a shared word
        always_ff @(posedge clk) begin
            if (rt_hit) lane_mem[rt_addr] <= rt_wdata[b*LANE_W +: LANE_W];
            if (lf_hit) lane_mem[lf_addr] <= lf_wdata[b*LANE_W +: LANE_W];
        end

        // read words forward the other port's write of the same cycle
        always_comb begin
            if (lf_hit && same_word)
                rt_rword[b*LANE_W +: LANE_W] = lf_wdata[b*LANE_W +: LANE_W];
            else if (rt_hit && same_word)
                rt_rword[b*LANE_W +: LANE_W] = rt_wdata[b*LANE_W +: LANE_W];
            else
                rt_rword[b*LANE_W +: LANE_W] = lane_mem[rt_addr];

            if (lf_hit && same_word)
                lf_rword[b*LANE_W +: LANE_W] = lf_wdata[b*LANE_W +: LANE_W];
            else if (rt_hit && same_word)
                lf_rword[b*LANE_W +: LANE_W] = rt_wdata[b*LANE_W +: LANE_W];
            else
                lf_rword[b*LANE_W +: LANE_W] = lane_mem[lf_addr];
        end
    end

endmodule

// File: rtl/dpr_port.sv
module dpr_port #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rnw,
    input  logic          oe_n,
    input  logic          block,
    input  logic [DW-1:0] rword,
    output logic          wr_go,
    output logic [DW-1:0] rdata,
    output logic          drive
);

    logic rd_go;

    always_comb begin
        wr_go = !cs_n && !rnw && !block;
        rd_go = !cs_n && rnw && !oe_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
            drive <= 1'b0;
        end else begin
            drive <= rd_go;
            rdata <= rd_go ? rword : '0;
        end
    end

endmodule

// File: rtl/dpr_top.sv
module dpr_top #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  master_i,
    input  logic                  lf_cs_n,
    input  logic                  lf_rnw,
    input  logic                  lf_oe_n,
    input  logic [DATA_W/8-1:0]   lf_be,
    input  logic [ADDR_W-1:0]     lf_addr,
    input  logic [DATA_W-1:0]     lf_wdata,
    output logic [DATA_W-1:0]     lf_rdata,
    output logic                  lf_drive,
    output logic                  lf_busy_o,
    input  logic                  lf_busy_i,
    input  logic                  rt_cs_n,
    input  logic                  rt_rnw,
    input  logic                  rt_oe_n,
    input  logic [DATA_W/8-1:0]   rt_be,
    input  logic [ADDR_W-1:0]     rt_addr,
    input  logic [DATA_W-1:0]     rt_wdata,
    output logic [DATA_W-1:0]     rt_rdata,
    output logic                  rt_drive,
    output logic                  rt_busy_o,
    input  logic                  rt_busy_i
);

    logic              lf_block, rt_block, lf_we, rt_we;
    logic [DATA_W-1:0] lf_rword, rt_rword;

    assign lf_block = master_i ? lf_busy_o : lf_busy_i;
    assign rt_block = master_i ? rt_busy_o : rt_busy_i;

    dpr_arbiter #(.AW(ADDR_W)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .master  (master_i),
        .lf_sel  (!lf_cs_n),
        .rt_sel  (!rt_cs_n),
        .lf_addr (lf_addr),
        .rt_addr (rt_addr),
        .lf_busy (lf_busy_o),
        .rt_busy (rt_busy_o)
    );

    dpr_port #(.DW(DATA_W)) u_lf (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (lf_cs_n),
        .rnw   (lf_rnw),
        .oe_n  (lf_oe_n),
        .block (lf_block),
        .rword (lf_rword),
        .wr_go (lf_we),
        .rdata (lf_rdata),
        .drive (lf_drive)
    );

    dpr_port #(.DW(DATA_W)) u_rt (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (rt_cs_n),
        .rnw   (rt_rnw),
        .oe_n  (rt_oe_n),
        .block (rt_block),
        .rword (rt_rword),
        .wr_go (rt_we),
        .rdata (rt_rdata),
        .drive (rt_drive)
    );

    dpr_store #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
        .clk      (clk),
        .lf_we    (lf_we),
        .lf_be    (lf_be),
        .lf_addr  (lf_addr),
        .lf_wdata (lf_wdata),
        .rt_we    (rt_we),
        .rt_be    (rt_be),
        .rt_addr  (rt_addr),
        .rt_wdata (rt_wdata),
        .lf_rword (lf_rword),
        .rt_rword (rt_rword)
    );

endmodule

// File: rtl/dpr_checker.sv
module dpr_checker #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              master_i,
    input logic              lf_cs_n,
    input logic              lf_oe_n,
    input logic [ADDR_W-1:0] lf_addr,
    input logic              lf_drive,
    input logic              lf_busy_o,
    input logic              rt_cs_n,
    input logic              rt_oe_n,
    input logic [ADDR_W-1:0] rt_addr,
    input logic              rt_drive,
    input logic              rt_busy_o
);

    logic clash;
    assign clash = !lf_cs_n && !rt_cs_n && (lf_addr == rt_addr);

    a_r5_never_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(lf_busy_o && rt_busy_o));

    a_r5_clash_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (master_i && clash) |-> (lf_busy_o || rt_busy_o));

    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        !clash |-> (!lf_busy_o && !rt_busy_o));

    a_r10_follower_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !master_i |-> (!lf_busy_o && !rt_busy_o));

    a_r6_left_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        rt_busy_o |=> (!clash || !master_i || rt_busy_o));

    a_r6_right_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        lf_busy_o |=> (!clash || !master_i || lf_busy_o));

    a_r2_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        lf_cs_n |=> !lf_drive);

    a_r2_oe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        rt_oe_n |=> !rt_drive);

endmodule

bind dpr_top dpr_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_dpr_top.sv
module test_dpr_top;

    localparam int AW = 6;
    localparam int DW = 32;
    localparam int NB = DW / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          master_i = 1'b1;
    logic          lf_cs_n = 1'b1, lf_rnw = 1'b1, lf_oe_n = 1'b1, lf_busy_i = 1'b0;
    logic [NB-1:0] lf_be = '0;
    logic [AW-1:0] lf_addr = '0;
    logic [DW-1:0] lf_wdata = '0;
    logic          rt_cs_n = 1'b1, rt_rnw = 1'b1, rt_oe_n = 1'b1, rt_busy_i = 1'b0;
    logic [NB-1:0] rt_be = '0;
    logic [AW-1:0] rt_addr = '0;
    logic [DW-1:0] rt_wdata = '0;
    logic [DW-1:0] lf_rdata, rt_rdata;
    logic          lf_drive, rt_drive, lf_busy_o, rt_busy_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    dpr_top #(.ADDR_W(AW), .DATA_W(DW)) i_dpr_top (.*);

    // {lf_cs_n, lf_addr[5:0], rt_cs_n, rt_addr[5:0], exp lf_busy, exp rt_busy}
    localparam logic [15:0] VEC [8] = '{
        {1'b0, 6'd5,  1'b0, 6'd5,  2'b01},
        {1'b0, 6'd5,  1'b0, 6'd6,  2'b00},
        {1'b1, 6'd5,  1'b0, 6'd5,  2'b00},
        {1'b0, 6'd5,  1'b1, 6'd5,  2'b00},
        {1'b0, 6'd63, 1'b0, 6'd63, 2'b01},
        {1'b0, 6'd0,  1'b0, 6'd0,  2'b01},
        {1'b0, 6'd0,  1'b0, 6'd32, 2'b00},
        {1'b1, 6'd7,  1'b1, 6'd7,  2'b00}
    };

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic lf_set(input logic cs_n, input logic rnw, input logic oe_n,
                          input logic [NB-1:0] be, input logic [AW-1:0] a, input logic [DW-1:0] d);
        lf_cs_n = cs_n; lf_rnw = rnw; lf_oe_n = oe_n; lf_be = be; lf_addr = a; lf_wdata = d;
    endtask

    task automatic rt_set(input logic cs_n, input logic rnw, input logic oe_n,
                          input logic [NB-1:0] be, input logic [AW-1:0] a, input logic [DW-1:0] d);
        rt_cs_n = cs_n; rt_rnw = rnw; rt_oe_n = oe_n; rt_be = be; rt_addr = a; rt_wdata = d;
    endtask

    task automatic idle;
        lf_set(1'b1, 1'b1, 1'b1, '0, '0, '0);
        rt_set(1'b1, 1'b1, 1'b1, '0, '0, '0);
    endtask

    initial begin
        #(4 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        tick; tick; tick;
        // R1 reset state
        chk("R1 lf_rdata", lf_rdata, '0);
        chk("R1 rt_rdata", rt_rdata, '0);
        chk("R1 drives", {30'd0, lf_drive, rt_drive}, '0);
        chk("R1 busy", {30'd0, lf_busy_o, rt_busy_o}, '0);
        rst_n = 1'b1;
        tick;

        // arrival table walk: R5 R7 R4 R9
        for (int i = 0; i < 8; i++) begin
            idle; tick;
            lf_set(VEC[i][15], 1'b1, 1'b0, '0, VEC[i][14:9], '0);
            rt_set(VEC[i][8], 1'b1, 1'b0, '0, VEC[i][7:2], '0);
            #1;
            chk($sformatf("R5/R7 vector %0d busy", i), {30'd0, lf_busy_o, rt_busy_o},
                {30'd0, VEC[i][1:0]});
            tick;
        end
        idle; tick;

        // R4 independent writes, then crossed reads (R2)
        lf_set(1'b0, 1'b0, 1'b1, 4'hF, 6'd3, 32'h11223344);
        rt_set(1'b0, 1'b0, 1'b1, 4'hF, 6'd4, 32'h55667788);
        #1 chk("R4 no busy on distinct writes", {30'd0, lf_busy_o, rt_busy_o}, '0);
        tick;
        lf_set(1'b0, 1'b1, 1'b0, '0, 6'd4, '0);
        rt_set(1'b0, 1'b1, 1'b0, '0, 6'd3, '0);
        tick;
        chk("R4 lf reads rt word", lf_rdata, 32'h55667788);
        chk("R4 rt reads lf word", rt_rdata, 32'h11223344);
        chk("R2 read drive", {31'd0, lf_drive}, 32'd1);

        // R3 byte lanes
        idle;
        lf_set(1'b0, 1'b0, 1'b1, 4'b0101, 6'd3, 32'hAABBCCDD);
        tick;
        lf_set(1'b0, 1'b1, 1'b0, '0, 6'd3, '0);
        tick;
        chk("R3 partial write", lf_rdata, 32'h11BB33DD);

        // R2 output enable high, then deselect
        lf_set(1'b0, 1'b1, 1'b1, '0, 6'd3, '0);
        tick;
        chk("R2 oe_n high drive", {31'd0, lf_drive}, '0);
        chk("R2 oe_n high data", lf_rdata, '0);
        lf_set(1'b1, 1'b1, 1'b0, '0, 6'd3, '0);
        tick;
        chk("R2 deselect drive", {31'd0, lf_drive}, '0);

        // R6 / R8: right arrives first, left write suppressed
        lf_set(1'b0, 1'b0, 1'b1, 4'hF, 6'd9, 32'h09090909);
        rt_set(1'b0, 1'b0, 1'b1, 4'hF, 6'd12, 32'h00000000);
        tick;
        idle;
        rt_set(1'b0, 1'b1, 1'b0, '0, 6'd9, '0);
        tick;
        lf_set(1'b0, 1'b0, 1'b1, 4'hF, 6'd9, 32'hDEADBEEF);
        #1 chk("R6 later port gets busy", {30'd0, lf_busy_o, rt_busy_o}, 32'd2);
        tick;
        #1 chk("R6 busy retained", {30'd0, lf_busy_o, rt_busy_o}, 32'd2);
        lf_set(1'b1, 1'b1, 1'b1, '0, 6'd9, '0);
        tick;
        idle;
        lf_set(1'b0, 1'b1, 1'b0, '0, 6'd9, '0);
        tick;
        chk("R8 suppressed write left word intact", lf_rdata, 32'h09090909);

        // R9 release on address change
        idle;
        rt_set(1'b0, 1'b1, 1'b0, '0, 6'd20, '0);
        tick;
        lf_set(1'b0, 1'b1, 1'b0, '0, 6'd20, '0);
        #1 chk("R9 clash present", {31'd0, lf_busy_o}, 32'd1);
        tick;
        rt_set(1'b0, 1'b1, 1'b0, '0, 6'd21, '0);
        #1 chk("R9 busy released", {30'd0, lf_busy_o, rt_busy_o}, '0);
        tick;

        // R11 pass-through: right owns and writes, left reads same cycle
        idle;
        rt_set(1'b0, 1'b0, 1'b1, 4'hF, 6'd10, 32'hA0A0A0A0);
        tick;
        rt_set(1'b0, 1'b0, 1'b1, 4'hF, 6'd10, 32'hB1B2B3B4);
        lf_set(1'b0, 1'b1, 1'b0, '0, 6'd10, '0);
        #1 chk("R11 reader flagged", {30'd0, lf_busy_o, rt_busy_o}, 32'd2);
        tick;
        chk("R11 reader sees fresh write", lf_rdata, 32'hB1B2B3B4);

        // R10 follower mode
        idle;
        master_i = 1'b0;
        lf_busy_i = 1'b1;
        lf_set(1'b0, 1'b0, 1'b1, 4'hF, 6'd12, 32'h12121212);
        rt_set(1'b0, 1'b1, 1'b0, '0, 6'd12, '0);
        #1 chk("R10 follower busy outputs low", {30'd0, lf_busy_o, rt_busy_o}, '0);
        tick;
        idle;
        lf_set(1'b0, 1'b1, 1'b0, '0, 6'd12, '0);
        tick;
        chk("R10 blocked write", lf_rdata, 32'h00000000);
        lf_busy_i = 1'b0;
        lf_set(1'b0, 1'b0, 1'b1, 4'hF, 6'd12, 32'h12121212);
        tick;
        lf_set(1'b0, 1'b1, 1'b0, '0, 6'd12, '0);
        tick;
        chk("R10 released write lands", lf_rdata, 32'h12121212);

        // R12 simultaneous unblocked writes to one word
        idle;
        lf_set(1'b0, 1'b0, 1'b1, 4'b0011, 6'd13, 32'h11111111);
        rt_set(1'b0, 1'b0, 1'b1, 4'b1111, 6'd13, 32'h22222222);
        tick;
        idle;
        rt_set(1'b0, 1'b1, 1'b0, '0, 6'd13, '0);
        tick;
        chk("R12 left lanes prevail", rt_rdata, 32'h22221111);

        idle;
        tick;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule